// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out the execute step of a loop instruction that combines a counter update with a conditional branch. A decoder picks one counter register and one action: count down, count up, or examine the value as it is. The unit forms the new counter value at that register's width and tests it for zero. It then decides whether the loop branch is taken, where the branch sense chosen by the instruction is either "taken on zero" or "taken on non-zero". For a taken branch it adds a 9-bit signed displacement to the address of the following instruction.

The surrounding core supplies the current contents of the selected register and the address of the next instruction. It writes the returned counter value back into its register file when the write-enable is high, and loads the returned program counter. The unit has no path to the condition flags, so flags set by earlier instructions reach later conditional branches unchanged. All outputs are registered and appear one clock after the request.

Top module: `loopctr_branch_unit`

## Requirements
- R1: Register select codes are A=0 and B=1, which are 8-bit counters, and D=2, X=3, Y=4 and SP=5, which are 16-bit counters. For an 8-bit counter, bits 15:8 of `count_i` are ignored, the update wraps at 8 bits, and `count_o[15:8]` is zero.
- R2: Action codes are 0 for decrement, 1 for increment and 2 for test only. Code 3 behaves as test only. A 16-bit counter wraps at 16 bits, so 0x0000 decrements to 0xFFFF and 0xFFFF increments to 0x0000.
- R3: With `on_zero_i`=1 the branch is taken when the updated value is zero at the register's width. With `on_zero_i`=0 it is taken when that value is non-zero.
- R4: `count_we_o` is high only for a decrement or increment of a legal register. For test only it stays low, and `count_o` shows the unchanged value at the register's width.
- R5: When the branch is taken, `pc_o` = `pc_next_i` + the sign-extended 9-bit `disp_i` (range -256 to +255, two's complement), taken modulo 2^16. When it is not taken, `pc_o` = `pc_next_i`.
- R6: Results appear on the clock edge after the one that samples `valid_i`=1, and `done_o` is high for that cycle. After a cycle with `valid_i`=0, `done_o`, `count_we_o` and `taken_o` are low.
- R7: Select codes 6 and 7 give no write and no branch, `count_o`=0 and `pc_o`=`pc_next_i`.
- R8: A synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present this cycle |
| sel_i | input | 3 | Counter register select |
| act_i | input | 2 | Counter action |
| on_zero_i | input | 1 | Branch sense: 1 = taken on zero, 0 = taken on non-zero |
| count_i | input | 16 | Current value of the selected register |
| disp_i | input | 9 | Signed branch displacement |
| pc_next_i | input | 16 | Address of the following instruction |
| done_o | output | 1 | Result valid |
| count_o | output | 16 | Updated counter value |
| count_we_o | output | 1 | Write the counter back |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 16 | Next program counter |

## Verification
The assertions check the following on every cycle:
- write-enable and taken appear only together with done;
- the returned PC matches the sampled next-instruction address, with or without the sign-extended displacement;
- a test-only action or an illegal select never writes;
- an 8-bit counter never returns a non-zero upper byte.

Only the bench's scenarios can show other properties. These are the arithmetic itself, with wrap at both widths in both directions; which sense leads to a taken branch; the displacement extremes; the PC wrapping below zero; and the reset behaviour in the middle of a run.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  typedef enum logic [1:0] {
    ACT_DEC = 2'd0,
    ACT_INC = 2'd1,
    ACT_TST = 2'd2,
    ACT_RSV = 2'd3
  } lcb_act_e;

  localparam logic [2:0] SEL_A  = 3'd0;
  localparam logic [2:0] SEL_B  = 3'd1;
  localparam logic [2:0] SEL_D  = 3'd2;
  localparam logic [2:0] SEL_X  = 3'd3;
  localparam logic [2:0] SEL_Y  = 3'd4;
  localparam logic [2:0] SEL_SP = 3'd5;

  function automatic logic sel_is_narrow(input logic [2:0] s);
    return (s == SEL_A) || (s == SEL_B);
  endfunction

  function automatic logic sel_is_legal(input logic [2:0] s);
    return s <= SEL_SP;
  endfunction
endpackage

// File: rtl/lcb_step.sv
module lcb_step #(
  parameter int W_WIDE   = 16,
  parameter int W_NARROW = 8
) (
  input  logic [W_WIDE-1:0] cnt_i,
  input  logic              narrow_i,
  input  logic [1:0]        act_i,
  output logic [W_WIDE-1:0] result_o,
  output logic              modify_o
);
  import lcb_pkg::*;

  localparam int PAD_W = W_WIDE - W_NARROW;
  localparam logic [W_WIDE-1:0] NARROW_MASK = {{PAD_W{1'b0}}, {W_NARROW{1'b1}}};

  logic [W_WIDE-1:0] adj;
  logic [W_WIDE-1:0] mask;

  always_comb begin
    case (act_i)
      ACT_DEC: adj = cnt_i - 1'b1;
      ACT_INC: adj = cnt_i + 1'b1;
      default: adj = cnt_i;
    endcase
  end

  assign mask     = narrow_i ? NARROW_MASK : {W_WIDE{1'b1}};
  assign result_o = adj & mask;
  assign modify_o = (act_i == ACT_DEC) || (act_i == ACT_INC);
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 9
) (
  input  logic [PC_W-1:0]   pc_next_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              take_i,
  output logic [PC_W-1:0]   pc_o
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign pc_o     = take_i ? (pc_next_i + disp_ext) : pc_next_i;
endmodule

// File: rtl/loopctr_branch_unit.sv
module loopctr_branch_unit #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int DISP_W = 9,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [2:0]        sel_i,
  input  logic [1:0]        act_i,
  input  logic              on_zero_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PC_W-1:0]   pc_next_i,
  output logic              done_o,
  output logic [DATA_W-1:0] count_o,
  output logic              count_we_o,
  output logic              taken_o,
  output logic [PC_W-1:0]   pc_o
);
  import lcb_pkg::*;

  localparam int EXT_W = PC_W - DISP_W;

  logic              narrow;
  logic              legal;
  logic [DATA_W-1:0] step_val;
  logic              step_mod;
  logic              is_zero;
  logic              take;
  logic [PC_W-1:0]   pc_calc;

  assign narrow = sel_is_narrow(sel_i);
  assign legal  = sel_is_legal(sel_i);

  lcb_step #(.W_WIDE(DATA_W), .W_NARROW(BYTE_W)) u_step (
    .cnt_i    (count_i),
    .narrow_i (narrow),
    .act_i    (act_i),
    .result_o (step_val),
    .modify_o (step_mod)
  );

  assign is_zero = (step_val == '0);
  assign take    = legal && (on_zero_i ? is_zero : !is_zero);

  lcb_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
    .pc_next_i (pc_next_i),
    .disp_i    (disp_i),
    .take_i    (take),
    .pc_o      (pc_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o     <= 1'b0;
      count_o    <= '0;
      count_we_o <= 1'b0;
      taken_o    <= 1'b0;
      pc_o       <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        count_o    <= legal ? step_val : '0;
        count_we_o <= legal && step_mod;
        taken_o    <= take;
        pc_o       <= pc_calc;
      end else begin
        count_we_o <= 1'b0;
        taken_o    <= 1'b0;
      end
    end
  end

  // R6
  we_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    count_we_o |-> done_o);

  // R6
  taken_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> done_o);

  // R5
  taken_pc_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (pc_o == $past(pc_next_i) +
                 {{EXT_W{$past(disp_i[DISP_W-1])}}, $past(disp_i)}));

  // R5
  fallthru_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !taken_o) |-> (pc_o == $past(pc_next_i)));

  // R4
  test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(act_i[1])) |-> !count_we_o);

  // R1
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(sel_i) <= SEL_B) |-> (count_o[DATA_W-1:BYTE_W] == '0));

  // R7
  illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(sel_i) > SEL_SP) |-> (!count_we_o && !taken_o));
endmodule

// File: tb/loopctr_branch_unit_bench.sv
`timescale 1ns/1ps
module loopctr_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [1:0]  act_i = '0;
  logic        on_zero_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [8:0]  disp_i = '0;
  logic [15:0] pc_next_i = '0;
  logic        done_o, count_we_o, taken_o;
  logic [15:0] count_o, pc_o;

  int n_checks = 0;
  int n_errs   = 0;

  always #10 clk = ~clk;

  loopctr_branch_unit u_loopctr_branch_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .sel_i(sel_i), .act_i(act_i),
    .on_zero_i(on_zero_i), .count_i(count_i), .disp_i(disp_i),
    .pc_next_i(pc_next_i), .done_o(done_o), .count_o(count_o),
    .count_we_o(count_we_o), .taken_o(taken_o), .pc_o(pc_o)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  act;
    logic        oz;
    logic [15:0] cnt;
    logic [8:0]  disp;
    logic [15:0] pcn;
    logic [15:0] e_cnt;
    logic        e_we;
    logic        e_tk;
    logic [15:0] e_pc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 1'b0, 16'h0000, 9'h010, 16'h1000, 16'h00FF, 1'b1, 1'b1, 16'h1010},
    '{3'd1, 2'd1, 1'b0, 16'hABFF, 9'h020, 16'h1000, 16'h0000, 1'b1, 1'b0, 16'h1000},
    '{3'd3, 2'd0, 1'b1, 16'h0000, 9'h020, 16'h1000, 16'hFFFF, 1'b1, 1'b0, 16'h1000},
    '{3'd4, 2'd1, 1'b1, 16'hFFFF, 9'h100, 16'h1000, 16'h0000, 1'b1, 1'b1, 16'h0F00},
    '{3'd2, 2'd2, 1'b1, 16'h0000, 9'h0FF, 16'h1000, 16'h0000, 1'b0, 1'b1, 16'h10FF},
    '{3'd5, 2'd2, 1'b1, 16'h1234, 9'h040, 16'h2000, 16'h1234, 1'b0, 1'b0, 16'h2000},
    '{3'd2, 2'd0, 1'b1, 16'h0001, 9'h1FE, 16'h0001, 16'h0000, 1'b1, 1'b1, 16'hFFFF},
    '{3'd0, 2'd0, 1'b0, 16'h0001, 9'h030, 16'h1000, 16'h0000, 1'b1, 1'b0, 16'h1000},
    '{3'd5, 2'd1, 1'b0, 16'h7FFF, 9'h005, 16'h3000, 16'h8000, 1'b1, 1'b1, 16'h3005},
    '{3'd1, 2'd2, 1'b1, 16'hFF00, 9'h001, 16'h1000, 16'h0000, 1'b0, 1'b1, 16'h1001},
    '{3'd3, 2'd3, 1'b0, 16'h0000, 9'h007, 16'h1000, 16'h0000, 1'b0, 1'b0, 16'h1000},
    '{3'd1, 2'd0, 1'b1, 16'h0000, 9'h011, 16'h4000, 16'h00FF, 1'b1, 1'b0, 16'h4000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [1:0] a, input logic oz,
                       input logic [15:0] c, input logic [8:0] d, input logic [15:0] p);
    valid_i = 1'b1; sel_i = s; act_i = a; on_zero_i = oz;
    count_i = c; disp_i = d; pc_next_i = p;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks + 1, n_errs);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R8 reset state
    chk("R8 done", done_o, 0);
    chk("R8 count", count_o, 0);
    chk("R8 we", count_we_o, 0);
    chk("R8 taken", taken_o, 0);
    chk("R8 pc", pc_o, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].sel, VECS[i].act, VECS[i].oz, VECS[i].cnt, VECS[i].disp, VECS[i].pcn);
      chk($sformatf("R6 done v%0d", i), done_o, 1);
      chk($sformatf("R2 count v%0d", i), count_o, VECS[i].e_cnt);
      chk($sformatf("R4 we v%0d", i), count_we_o, VECS[i].e_we);
      chk($sformatf("R3 taken v%0d", i), taken_o, VECS[i].e_tk);
      chk($sformatf("R5 pc v%0d", i), pc_o, VECS[i].e_pc);
    end

    // R1 upper byte of an 8-bit counter ignored
    drive(3'd0, 2'd0, 1'b0, 16'h5A03, 9'h002, 16'h1000);
    chk("R1 narrow count", count_o, 16'h0002);
    chk("R1 narrow taken", taken_o, 1);
    chk("R1 narrow pc", pc_o, 16'h1002);

    // R7 illegal selects
    drive(3'd6, 2'd0, 1'b0, 16'h0005, 9'h010, 16'h1000);
    chk("R7 sel6 we", count_we_o, 0);
    chk("R7 sel6 taken", taken_o, 0);
    chk("R7 sel6 count", count_o, 0);
    chk("R7 sel6 pc", pc_o, 16'h1000);
    drive(3'd7, 2'd1, 1'b1, 16'hFFFF, 9'h010, 16'h2222);
    chk("R7 sel7 taken", taken_o, 0);
    chk("R7 sel7 pc", pc_o, 16'h2222);

    // R6 idle cycle after a write
    drive(3'd3, 2'd0, 1'b0, 16'h0009, 9'h004, 16'h1000);
    @(negedge clk);
    chk("R6 idle done", done_o, 0);
    chk("R6 idle we", count_we_o, 0);
    chk("R6 idle taken", taken_o, 0);

    // R8 reset in the middle of a run
    valid_i = 1'b1; sel_i = 3'd4; act_i = 2'd0; on_zero_i = 1'b0;
    count_i = 16'h0010; disp_i = 9'h008; pc_next_i = 16'h5000;
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid done", done_o, 0);
    chk("R8 mid we", count_we_o, 0);
    chk("R8 mid pc", pc_o, 0);
    rst = 1'b0; valid_i = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule